// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block decides when an LCD panel's logic signals and its separate panel supply are switched on and off, and in what order. The logic side must be running before the supply comes up. On the way down the supply goes first, and the logic is kept running while the supply discharges. All delays are counted in vertical non-display periods. A display timing generator delivers each period as a one-clock pulse.

A power request comes from either of two sources. One is a two-bit software power-save field, which requests power when it reads binary 11. The other is an active-high hardware power-save pin, which requests power when it is low. With no further help, the block runs a fixed automatic sequence: the panel supply comes up at the first frame pulse after the logic is enabled. After a power-down request, the logic stays on for a fixed number of frames. A power-override bit holds the panel supply off in every state. Software can use this bit to stretch the gap between logic and supply, in either direction, beyond the built-in delay. Status copies of both enables and a busy flag for the discharge wait come out as plain pins.

Top module: `lcd_pwr_seq`

## Requirements
- R1: A synchronous active-high `rst` drives `logic_en`, `panel_en` and `busy` low. After `rst` is released, the block is idle and the discharge count is cleared.
- R2: From idle, `logic_en` goes high one clock after power is requested. Power is requested when `sw_save` equals 2'b11 or `hw_save` is 0. Any other input combination leaves `logic_en` low.
- R3: With `pwr_override` low, `panel_en` rises on the clock edge that samples the first `frame_tick` after `logic_en` is high. It never rises earlier.
- R4: While `pwr_override` is 1, `panel_en` is 0 in the same cycle, whatever the state. Clearing the bit while powered brings `panel_en` back in the same cycle.
- R5: While `pwr_override` is 1 and the logic is on, frame ticks do not power the panel. Once the bit is cleared, `panel_en` waits for the next `frame_tick`.
- R6: When the request is withdrawn while the panel is powered, `panel_en` falls one clock later. At the same time `busy` rises and `logic_en` stays high.
- R7: The discharge wait lasts `DRAIN_FRAMES` frame ticks (default 127). `logic_en` and `busy` fall on the clock edge that samples the last of those ticks.
- R8: A request that returns during the discharge wait does not shorten it. After the wait ends, `logic_en` returns one clock later and `panel_en` follows at the next `frame_tick`.
- R9: When the request is withdrawn before the panel was ever powered, `logic_en` falls one clock later and `busy` never rises.
- R10: `stat_logic`, `stat_panel` and `busy` are read-only status pins. `stat_logic` and `stat_panel` always equal `logic_en` and `panel_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle pulse per vertical non-display period |
| sw_save | input | 2 | Software power-save field; 2'b11 requests power |
| hw_save | input | 1 | Hardware power-save pin, active high; 0 requests power |
| pwr_override | input | 1 | 1 holds panel power off |
| logic_en | output | 1 | Enables the panel logic signals |
| panel_en | output | 1 | Enables the panel power supply |
| stat_logic | output | 1 | Status copy of logic_en |
| stat_panel | output | 1 | Status copy of panel_en |
| busy | output | 1 | High while the discharge wait runs |

## Verification
The hardest situation to reach is a power request that returns near the end of a discharge wait. The stimulus gets there in four steps. It powers the panel fully and withdraws the request. It then feeds 126 single-cycle frame pulses, re-raising the software field partway through. The 127th pulse then checks that the logic drops exactly at that edge and returns one clock later. The override cases are reached by holding the bit across several frame pulses in the logic-only state, and then toggling it between clock edges while powered.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_LOGIC = 2'd1,
    ST_POWER = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;

  localparam logic [1:0] SW_RUN_CODE = 2'b11;

endpackage

// File: rtl/lcd_pwr_req.sv
module lcd_pwr_req
  import lcd_pwr_pkg::*;
(
  input  logic [1:0] sw_save,
  input  logic       hw_save,
  output logic       want_on
);
  // Either source may request power: software field at run code, or pin low.
  assign want_on = (sw_save == SW_RUN_CODE) || !hw_save;
endmodule

// File: rtl/lcd_pwr_frame_cnt.sv
module lcd_pwr_frame_cnt #(
  parameter int CNT_W  = 7,
  parameter int FRAMES = 127
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
  import lcd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       want_on,
  input  logic       frame_tick,
  input  logic       pwr_override,
  input  logic       drain_last,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (want_on) nxt = ST_LOGIC;
      ST_LOGIC: begin
        if (!want_on)                        nxt = ST_OFF;
        else if (frame_tick && !pwr_override) nxt = ST_POWER;
      end
      ST_POWER: if (!want_on) nxt = ST_DRAIN;
      ST_DRAIN: if (frame_tick && drain_last) nxt = ST_OFF;
      default:  nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_pkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int DRAIN_FRAMES = 127
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_tick,
  input  logic [1:0] sw_save,
  input  logic       hw_save,
  input  logic       pwr_override,
  output logic       logic_en,
  output logic       panel_en,
  output logic       stat_logic,
  output logic       stat_panel,
  output logic       busy
);
  logic       want_on;
  logic       drain_last;
  seq_state_t state;
  logic       in_drain;

  lcd_pwr_req u_req (
    .sw_save (sw_save),
    .hw_save (hw_save),
    .want_on (want_on)
  );

  lcd_pwr_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .want_on      (want_on),
    .frame_tick   (frame_tick),
    .pwr_override (pwr_override),
    .drain_last   (drain_last),
    .state        (state)
  );

  assign in_drain = (state == ST_DRAIN);

  lcd_pwr_frame_cnt #(
    .CNT_W  (CNT_W),
    .FRAMES (DRAIN_FRAMES)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (!in_drain),
    .adv  (in_drain && frame_tick),
    .last (drain_last)
  );

  assign logic_en   = (state != ST_OFF);
  assign panel_en   = (state == ST_POWER) && !pwr_override;
  assign busy       = in_drain;
  assign stat_logic = logic_en;
  assign stat_panel = panel_en;
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic pwr_override,
  input logic logic_en,
  input logic panel_en,
  input logic busy
);
  a_r3_panel_needs_logic: assert property (@(posedge clk) disable iff (rst)
    panel_en |-> logic_en);

  a_r4_override_blocks_panel: assert property (@(posedge clk) disable iff (rst)
    pwr_override |-> !panel_en);

  a_r6_panel_off_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!panel_en && logic_en));

  a_r7_logic_falls_after_panel: assert property (@(posedge clk) disable iff (rst)
    $fell(logic_en) |-> !$past(panel_en));

  a_r9_busy_enters_from_logic: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(logic_en));
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_override (pwr_override),
  .logic_en     (logic_en),
  .panel_en     (panel_en),
  .busy         (busy)
);

// File: tb/lcd_pwr_seq_bench.sv
module lcd_pwr_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic [1:0] sw_save = 2'b00;
  logic       hw_save = 1'b1;
  logic       pwr_override = 1'b0;
  logic       logic_en, panel_en, stat_logic, stat_panel, busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  lcd_pwr_seq u_lcd_pwr_seq (
    .clk          (clk),
    .rst          (rst),
    .frame_tick   (frame_tick),
    .sw_save      (sw_save),
    .hw_save      (hw_save),
    .pwr_override (pwr_override),
    .logic_en     (logic_en),
    .panel_en     (panel_en),
    .stat_logic   (stat_logic),
    .stat_panel   (stat_panel),
    .busy         (busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sw_save = 2'b00; hw_save = 1'b1; pwr_override = 1'b0; frame_tick = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 logic_en after reset", logic_en, 1'b0);
    chk("R1 panel_en after reset", panel_en, 1'b0);
    chk("R1 busy after reset", busy, 1'b0);
  endtask

  task automatic t_auto_up();
    do_reset();
    sw_save = 2'b11;
    @(negedge clk);
    chk("R2 logic_en from sw 11", logic_en, 1'b1);
    chk("R3 panel_en before tick", panel_en, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 panel_en still off without tick", panel_en, 1'b0);
    tick();
    chk("R3 panel_en after first tick", panel_en, 1'b1);
    chk("R10 stat_panel mirrors", stat_panel, 1'b1);
    chk("R10 stat_logic mirrors", stat_logic, 1'b1);
  endtask

  task automatic t_hw_pin();
    do_reset();
    sw_save = 2'b10; hw_save = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 sw 10 with pin high stays off", logic_en, 1'b0);
    hw_save = 1'b0;
    @(negedge clk);
    chk("R2 logic_en from hw pin low", logic_en, 1'b1);
  endtask

  task automatic t_override();
    do_reset();
    pwr_override = 1'b1;
    sw_save = 2'b11;
    @(negedge clk);
    repeat (3) tick();
    chk("R5 override holds panel off over ticks", panel_en, 1'b0);
    chk("R5 logic stays on under override", logic_en, 1'b1);
    pwr_override = 1'b0;
    @(negedge clk);
    chk("R5 panel waits for tick after clear", panel_en, 1'b0);
    tick();
    chk("R5 panel on at tick after clear", panel_en, 1'b1);
    pwr_override = 1'b1;
    #1;
    chk("R4 override kills panel same cycle", panel_en, 1'b0);
    chk("R10 stat_panel follows override", stat_panel, 1'b0);
    pwr_override = 1'b0;
    #1;
    chk("R4 panel back when override clears", panel_en, 1'b1);
  endtask

  task automatic t_drain();
    do_reset();
    sw_save = 2'b11;
    @(negedge clk);
    tick();
    chk("R3 powered before drain", panel_en, 1'b1);
    sw_save = 2'b00;
    @(negedge clk);
    chk("R6 panel off after withdraw", panel_en, 1'b0);
    chk("R6 logic held during drain", logic_en, 1'b1);
    chk("R6 busy high during drain", busy, 1'b1);
    for (int i = 0; i < 126; i++) begin
      if (i == 60) sw_save = 2'b11;
      tick();
    end
    chk("R7 logic still on after 126 ticks", logic_en, 1'b1);
    chk("R8 busy holds with request back", busy, 1'b1);
    chk("R8 panel stays off during drain", panel_en, 1'b0);
    tick();
    chk("R7 logic off at 127th tick", logic_en, 1'b0);
    chk("R7 busy off at 127th tick", busy, 1'b0);
    @(negedge clk);
    chk("R8 logic back one clock later", logic_en, 1'b1);
    chk("R8 panel waits for tick", panel_en, 1'b0);
    tick();
    chk("R8 panel on at next tick", panel_en, 1'b1);
  endtask

  task automatic t_early_drop();
    do_reset();
    sw_save = 2'b11;
    @(negedge clk);
    sw_save = 2'b01;
    @(negedge clk);
    chk("R9 logic off when dropped before power", logic_en, 1'b0);
    chk("R9 no busy when never powered", busy, 1'b0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    hw_save = 1'b0;
    @(negedge clk);
    tick();
    hw_save = 1'b1;
    @(negedge clk);
    repeat (5) tick();
    chk("R6 busy before mid reset", busy, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid drain clears logic", logic_en, 1'b0);
    chk("R1 reset mid drain clears busy", busy, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset release", logic_en, 1'b0);
  endtask

  initial begin
    #(8 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_auto_up();
    t_hw_pin();
    t_override();
    t_drain();
    t_early_drop();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule